// File: doc/BRIEF.md
# Delayed-Write Store Stage for a Direct-Mapped Cache

This block is the memory-stage front end of a small direct-mapped cache in which a store hit finishes in a single cycle. In its own cycle a store only reads and compares the tag. If it hits, its word address, data and byte enables are parked in a one-entry holding register instead of being written to the data array. The parked bytes reach the data array later, in a cycle when the array has no other user. That cycle is the tag-check cycle of the next store, or the first cycle without a load or line install after a flush request.

A load reads the tag array and the data array in the same cycle. When a load addresses the parked word, the bytes covered by the parked byte enables come from the holding register and the other bytes come from the array. Lines are installed through a line-install port that writes a whole line together with its tag and valid bit. Each line is one data word of `NBYTES` bytes. An address splits, from the least significant bit upward, into a byte offset of log2(`NBYTES`) bits (ignored), an index of `INDEX_W` bits, and a tag made of the remaining upper bits.

Top module: `dwc_store_stage`

## Requirements
- R1: A request (`req_valid` high with `fill_valid` low) gets `rsp_valid` high exactly one cycle later. `rsp_hit` is high when the indexed line is valid and its stored tag equals the request tag.
- R2: A load miss returns `rsp_rdata` equal to 0. Every store response also returns `rsp_rdata` equal to 0.
- R3: A store hit does not write the data array in its own cycle. It parks its word address, data and byte enables, and `wb_pending` is high in the next cycle.
- R4: Every store cycle, hit or miss, writes any previously parked entry into the data array. Byte i is `data[8i+7:8i]` and is gated by enable bit i.
- R5: When a store hits the same word as the parked entry, the older entry is written to the array first and the new store then replaces it. A later load sees the bytes of both stores.
- R6: A store miss parks nothing, so `wb_pending` is low in the following cycle.
- R7: A load hit to the parked word returns each byte whose parked enable bit is set from the holding register, and every other byte from the array.
- R8: A load never writes the data array and never disturbs the parked entry.
- R9: After `flush` is pulsed with an entry parked, the entry is written in the first cycle, from the pulse onward, that has neither a load nor a line install. `wb_pending` is low in the next cycle. A flush with nothing parked has no effect.
- R10: A line install writes the whole line, its tag, and a valid bit. If the parked entry has the same index and the same tag, its enabled bytes overlay the installed data. A parked entry at the same index is dropped in either case.
- R11: After reset all lines are invalid, nothing is parked, and `rsp_valid` is low.
- R12: When `fill_valid` and `req_valid` are high in the same cycle, the install takes place and the request is ignored, so no response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load or store request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 8*NBYTES | Store data |
| req_be | input | NBYTES | Store byte enables |
| fill_valid | input | 1 | Line install this cycle |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_data | input | 8*NBYTES | Data of the installed line |
| flush | input | 1 | Pulse that asks for the parked entry to be written |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | Tag hit of that request |
| rsp_rdata | output | 8*NBYTES | Load data (0 on a miss and for stores) |
| wb_pending | output | 1 | An entry is parked |

## Verification
The bench aims at the cycles in which the data array has two possible users. These are back-to-back stores to the same word, a load right after a partial-byte store, a flush that arrives while loads keep the array busy, and a line install on the parked index. A design that updated the holding register before writing the older entry would lose bytes of the first store. A design that forwarded whole words instead of enabled bytes would return stale or zero bytes on a partial load. A design that let a flush write during a load, or kept a parked entry after a line install, would leave stale or wrong data that later loads expose. Long mixed traffic over two tags per index is then compared against a behavioural model on every clock.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_FILL  = 2'd3
  } dwc_op_e;
endpackage

// File: rtl/dwc_tag_store.sv
module dwc_tag_store #(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 7,
  localparam int LINES  = 1 << INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag
);
  logic [LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dwc_data_store.sv
module dwc_data_store #(
  parameter int INDEX_W = 3,
  parameter int NBYTES  = 4,
  localparam int LINES  = 1 << INDEX_W,
  localparam int DATA_W = 8 * NBYTES
) (
  input  logic               clk,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NBYTES-1:0]  wr_be
);
  logic [DATA_W-1:0] mem_q [LINES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) mem_q[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/dwc_pend_buf.sv
module dwc_pend_buf #(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 7,
  parameter int NBYTES  = 4,
  localparam int DATA_W = 8 * NBYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic               clr_en,
  input  logic [TAG_W-1:0]   ld_tag,
  input  logic [INDEX_W-1:0] ld_idx,
  input  logic [DATA_W-1:0]  ld_data,
  input  logic [NBYTES-1:0]  ld_be,
  input  logic [TAG_W-1:0]   byp_tag,
  input  logic [INDEX_W-1:0] byp_idx,
  input  logic [DATA_W-1:0]  byp_base,
  output logic [DATA_W-1:0]  byp_out,
  input  logic [TAG_W-1:0]   fl_tag,
  input  logic [INDEX_W-1:0] fl_idx,
  input  logic [DATA_W-1:0]  fl_base,
  output logic [DATA_W-1:0]  fl_out,
  output logic               fl_same_idx,
  output logic               pv_o,
  output logic [INDEX_W-1:0] pidx_o,
  output logic [DATA_W-1:0]  pdata_o,
  output logic [NBYTES-1:0]  pbe_o
);
  logic               pv_q, pv_d;
  logic [TAG_W-1:0]   ptag_q;
  logic [INDEX_W-1:0] pidx_q;
  logic [DATA_W-1:0]  pdata_q;
  logic [NBYTES-1:0]  pbe_q;
  logic               byp_hit, fl_hit;

  always_comb begin
    pv_d = pv_q;
    if (clr_en) pv_d = 1'b0;
    if (ld_en)  pv_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv_q <= 1'b0;
    else        pv_q <= pv_d;
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      ptag_q  <= ld_tag;
      pidx_q  <= ld_idx;
      pdata_q <= ld_data;
      pbe_q   <= ld_be;
    end
  end

  assign byp_hit     = pv_q && (ptag_q == byp_tag) && (pidx_q == byp_idx);
  assign fl_same_idx = pv_q && (pidx_q == fl_idx);
  assign fl_hit      = fl_same_idx && (ptag_q == fl_tag);

  for (genvar b = 0; b < NBYTES; b++) begin : g_merge
    assign byp_out[8*b +: 8] = (byp_hit && pbe_q[b]) ? pdata_q[8*b +: 8] : byp_base[8*b +: 8];
    assign fl_out[8*b +: 8]  = (fl_hit && pbe_q[b])  ? pdata_q[8*b +: 8] : fl_base[8*b +: 8];
  end

  assign pv_o    = pv_q;
  assign pidx_o  = pidx_q;
  assign pdata_o = pdata_q;
  assign pbe_o   = pbe_q;
endmodule

// File: rtl/dwc_store_stage.sv
module dwc_store_stage #(
  parameter int ADDR_W  = 12,
  parameter int INDEX_W = 3,
  parameter int NBYTES  = 4,
  localparam int OFFSET_W = $clog2(NBYTES),
  localparam int DATA_W   = 8 * NBYTES,
  localparam int TAG_W    = ADDR_W - INDEX_W - OFFSET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NBYTES-1:0] req_be,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              flush,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wb_pending
);
  import dwc_pkg::*;

  dwc_op_e op;
  logic [INDEX_W-1:0] req_idx, fill_idx, pidx;
  logic [TAG_W-1:0]   req_tag, fill_tag;
  logic               line_valid, tag_hit;
  logic [TAG_W-1:0]   line_tag;
  logic [DATA_W-1:0]  arr_rdata, byp_data, fill_merged, pdata;
  logic [NBYTES-1:0]  pbe;
  logic               pv, fl_same_idx;
  logic               flush_q, flush_d, flush_any;
  logic               commit, pend_ld, pend_clr;
  logic               dwr_en;
  logic [INDEX_W-1:0] dwr_idx;
  logic [DATA_W-1:0]  dwr_data;
  logic [NBYTES-1:0]  dwr_be;
  logic               rsp_valid_d, rsp_hit_d;
  logic [DATA_W-1:0]  rsp_rdata_d;
  logic               unused_offset_bits;

  assign unused_offset_bits = ^{req_addr[OFFSET_W-1:0], fill_addr[OFFSET_W-1:0]};

  assign req_idx  = req_addr[OFFSET_W +: INDEX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign fill_idx = fill_addr[OFFSET_W +: INDEX_W];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    if (fill_valid)     op = OP_FILL;
    else if (!req_valid) op = OP_IDLE;
    else if (req_store) op = OP_STORE;
    else                op = OP_LOAD;
  end

  dwc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .wr_en    (op == OP_FILL),
    .wr_idx   (fill_idx),
    .wr_tag   (fill_tag)
  );

  assign tag_hit = line_valid && (line_tag == req_tag);

  dwc_pend_buf #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .NBYTES(NBYTES)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_en       (pend_ld),
    .clr_en      (pend_clr),
    .ld_tag      (req_tag),
    .ld_idx      (req_idx),
    .ld_data     (req_wdata),
    .ld_be       (req_be),
    .byp_tag     (req_tag),
    .byp_idx     (req_idx),
    .byp_base    (arr_rdata),
    .byp_out     (byp_data),
    .fl_tag      (fill_tag),
    .fl_idx      (fill_idx),
    .fl_base     (fill_data),
    .fl_out      (fill_merged),
    .fl_same_idx (fl_same_idx),
    .pv_o        (pv),
    .pidx_o      (pidx),
    .pdata_o     (pdata),
    .pbe_o       (pbe)
  );

  // Array arbitration: an install owns the array; otherwise the parked
  // entry drains in a store cycle or in a load-free cycle under flush.
  assign flush_any = flush || flush_q;
  assign commit    = pv && ((op == OP_STORE) ||
                            (flush_any && (op == OP_IDLE)));
  assign pend_ld   = (op == OP_STORE) && tag_hit;
  assign pend_clr  = commit || ((op == OP_FILL) && fl_same_idx);
  assign flush_d   = flush_any && pv && !pend_clr;

  always_comb begin
    dwr_en   = 1'b0;
    dwr_idx  = pidx;
    dwr_data = pdata;
    dwr_be   = pbe;
    if (op == OP_FILL) begin
      dwr_en   = 1'b1;
      dwr_idx  = fill_idx;
      dwr_data = fill_merged;
      dwr_be   = '1;
    end else if (commit) begin
      dwr_en   = 1'b1;
    end
  end

  dwc_data_store #(.INDEX_W(INDEX_W), .NBYTES(NBYTES)) u_data (
    .clk     (clk),
    .rd_idx  (req_idx),
    .rd_data (arr_rdata),
    .wr_en   (dwr_en),
    .wr_idx  (dwr_idx),
    .wr_data (dwr_data),
    .wr_be   (dwr_be)
  );

  always_comb begin
    rsp_valid_d = (op == OP_LOAD) || (op == OP_STORE);
    rsp_hit_d   = rsp_valid_d && tag_hit;
    rsp_rdata_d = ((op == OP_LOAD) && tag_hit) ? byp_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      flush_q   <= flush_d;
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

  assign wb_pending = pv;
endmodule

// File: rtl/dwc_store_stage_chk.sv
module dwc_store_stage_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_store,
  input logic              fill_valid,
  input logic              flush,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              wb_pending
);
  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (rsp_valid == $past(req_valid && !fill_valid)));

  p_miss_zero_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_rdata == '0));

  p_store_hit_parks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && $past(req_store)) |-> wb_pending);

  p_store_miss_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && $past(req_store)) |-> !wb_pending);

  p_load_keeps_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && !fill_valid && wb_pending) |=> wb_pending);

  p_flush_drains_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && wb_pending && !req_valid && !fill_valid) |=> !wb_pending);

  p_fill_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !rsp_valid);
endmodule

bind dwc_store_stage dwc_store_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_store  (req_store),
  .fill_valid (fill_valid),
  .flush      (flush),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_rdata  (rsp_rdata),
  .wb_pending (wb_pending)
);

// File: tb/tb_dwc_store_stage.sv
module tb_dwc_store_stage;
  localparam int ADDR_W = 12;
  localparam int INDEX_W = 3;
  localparam int NBYTES = 4;
  localparam int DATA_W = 32;
  localparam int LINES = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_store, fill_valid, flush;
  logic [ADDR_W-1:0] req_addr, fill_addr;
  logic [DATA_W-1:0] req_wdata, fill_data;
  logic [NBYTES-1:0] req_be;
  logic rsp_valid, rsp_hit, wb_pending;
  logic [DATA_W-1:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_data [LINES];
  int          m_tag  [LINES];
  bit          m_val  [LINES];
  bit          pv, fq;
  int          ptag, pidx;
  logic [31:0] pdata;
  logic [3:0]  pbe;
  bit          e_rv, e_hit;
  logic [31:0] e_rd;

  always #5 clk = ~clk;

  dwc_store_stage #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .NBYTES(NBYTES)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_rdata(rsp_rdata), .wb_pending(wb_pending)
  );

  function automatic logic [31:0] overlay(logic [31:0] base, logic [31:0] ov, logic [3:0] be);
    logic [31:0] r = base;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = ov[8*i +: 8];
    return r;
  endfunction

  function automatic logic [11:0] mk(int tag, int idx);
    return {tag[6:0], idx[2:0], 2'b00};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int i, t, fi, ft;
    bit hit, commit;
    logic [31:0] line;
    bit fl_any = flush || fq;
    i = int'(req_addr[4:2]); t = int'(req_addr[11:5]);
    fi = int'(fill_addr[4:2]); ft = int'(fill_addr[11:5]);
    e_rv = 0; e_hit = 0; e_rd = '0;
    if (fill_valid) begin
      line = fill_data;
      if (pv && pidx == fi) begin
        if (ptag == ft) line = overlay(line, pdata, pbe);
        pv = 0;
      end
      m_data[fi] = line; m_tag[fi] = ft; m_val[fi] = 1;
      fq = fl_any && pv;
    end else if (req_valid) begin
      hit = m_val[i] && m_tag[i] == t;
      e_rv = 1; e_hit = hit;
      if (req_store) begin
        if (pv) m_data[pidx] = overlay(m_data[pidx], pdata, pbe);
        commit = pv;
        pv = 0;
        fq = 0;
        if (hit) begin
          pv = 1; ptag = t; pidx = i; pdata = req_wdata; pbe = req_be;
        end
        if (!commit) fq = 0;
      end else begin
        if (hit) begin
          e_rd = m_data[i];
          if (pv && pidx == i && ptag == t) e_rd = overlay(e_rd, pdata, pbe);
        end
        fq = fl_any && pv;
      end
    end else begin
      if (fl_any && pv) begin
        m_data[pidx] = overlay(m_data[pidx], pdata, pbe);
        pv = 0;
      end
      fq = 0;
    end
  endtask

  task automatic cyc(string req, bit rv, bit st, logic [11:0] a, logic [31:0] wd,
                     logic [3:0] be, bit fv, logic [11:0] fa, logic [31:0] fd, bit fl);
    @(negedge clk);
    req_valid = rv; req_store = st; req_addr = a; req_wdata = wd; req_be = be;
    fill_valid = fv; fill_addr = fa; fill_data = fd; flush = fl;
    @(posedge clk);
    model_step();
    #1;
    check(req, "rsp_valid", 32'(rsp_valid), 32'(e_rv));
    check(req, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
    check(req, "rsp_rdata", rsp_rdata, e_rd);
    check(req, "wb_pending", 32'(wb_pending), 32'(pv));
  endtask

  task automatic ld(string req, logic [11:0] a);
    cyc(req, 1, 0, a, '0, '0, 0, '0, '0, 0);
  endtask
  task automatic st(string req, logic [11:0] a, logic [31:0] d, logic [3:0] be);
    cyc(req, 1, 1, a, d, be, 0, '0, '0, 0);
  endtask
  task automatic fill(string req, logic [11:0] a, logic [31:0] d);
    cyc(req, 0, 0, '0, '0, '0, 1, a, d, 0);
  endtask
  task automatic idle(string req, bit fl);
    cyc(req, 0, 0, '0, '0, '0, 0, '0, '0, fl);
  endtask

  initial begin
    int cnt = 0;
    while (!done && cnt < 100000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    req_valid = 0; req_store = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    fill_valid = 0; fill_addr = '0; fill_data = '0; flush = 0;
    pv = 0; fq = 0; ptag = 0; pidx = 0; pdata = '0; pbe = '0;
    for (int k = 0; k < LINES; k++) begin m_val[k] = 0; m_tag[k] = 0; m_data[k] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check("R11", "rsp_valid after reset", 32'(rsp_valid), 0);
    check("R11", "wb_pending after reset", 32'(wb_pending), 0);
    @(negedge clk); rst_n = 1;

    ld("R11", mk(0, 0));                  // all lines invalid
    for (int k = 0; k < LINES; k++) fill("R10", mk(1, k), 32'h1000_0000 + k * 32'h0101_0101);
    ld("R1", mk(1, 3));
    ld("R2", mk(2, 3));                   // tag mismatch
    st("R3", mk(1, 2), 32'hAABB_CCDD, 4'b0011);
    ld("R7", mk(1, 2));                   // partial bypass
    ld("R8", mk(1, 5));
    ld("R8", mk(1, 2));
    st("R5", mk(1, 2), 32'h1122_3344, 4'b1100);
    ld("R5", mk(1, 2));
    st("R4", mk(1, 6), 32'h5566_7788, 4'b1111);
    ld("R4", mk(1, 2));                   // first two stores now in array
    st("R6", mk(3, 4), 32'hDEAD_BEEF, 4'b1111);
    ld("R6", mk(1, 6));
    ld("R6", mk(1, 4));
    st("R9", mk(1, 1), 32'hCAFE_F00D, 4'b0110);
    cyc("R9", 1, 0, mk(1, 7), '0, '0, 0, '0, '0, 1);   // flush while load busy
    ld("R9", mk(1, 1));
    idle("R9", 0);                                    // drains here
    ld("R9", mk(1, 1));
    idle("R9", 1);                                    // nothing parked
    st("R10", mk(1, 5), 32'h0BAD_0BAD, 4'b1001);
    fill("R10", mk(1, 5), 32'h7777_7777);             // same tag: overlay
    ld("R10", mk(1, 5));
    st("R10", mk(1, 0), 32'h0123_4567, 4'b1111);
    fill("R10", mk(4, 0), 32'h8888_8888);             // different tag: drop
    ld("R10", mk(4, 0));
    ld("R10", mk(1, 0));
    cyc("R12", 1, 0, mk(1, 3), '0, '0, 1, mk(1, 3), 32'h3333_3333, 0);
    ld("R12", mk(1, 3));

    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      logic [11:0] a = mk($urandom_range(1, 2), $urandom_range(0, 7));
      if (r < 8)       cyc("R1", 0, 0, '0, '0, '0, 1, a, $urandom, $urandom_range(0, 9) == 0);
      else if (r < 45) cyc("R7", 1, 0, a, '0, '0, 0, '0, '0, $urandom_range(0, 9) == 0);
      else if (r < 80) cyc("R4", 1, 1, a, $urandom, 4'($urandom), 0, '0, '0, 0);
      else             cyc("R9", 0, 0, '0, '0, '0, 0, '0, '0, $urandom_range(0, 3) == 0);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule